// File: doc/BRIEF.md
# Support Change Detector

The detector watches a stream of fixed-point sample bundles and flags energy that the current support assumption cannot explain. A control row, one signed coefficient per lane, is written into a small coefficient store through an indexed write port. Each cycle that carries a valid bundle, the block multiplies every lane by its coefficient and sums the products in a pipelined adder tree. It rescales the dot product to the sample Q-format, squares it into an energy value and pushes that energy into an eight-entry history.

The mean of the history (the sum shifted right by three) is compared against a user-supplied threshold that uses the same Q-format. Once the history holds eight results, the registered flag goes high whenever the mean is strictly greater than the threshold. The block accepts one bundle per clock. Writing a coefficient restarts the observation window, because a new row makes old energies meaningless.

Top module: `support_change_det`

## Requirements
- R1: While reset is high and in the first cycle after it, `support_changed` is 0 and every coefficient is 0.
- R2: Lane i of `smp_bundle` occupies bits [18*i+17 : 18*i] as a signed value. The coefficient for lane i is written by a cycle with `row_we`=1 and `row_idx`=i, and the dot product is the sum over all 24 lanes of sample times coefficient.
- R3: With F fractional bits (default 14), the scaled dot product is floor(dot / 2^F). The energy is floor(scaled^2 / 2^F), an unsigned value in the same Q-format as the threshold.
- R4: The mean is floor(sum of the eight newest energies / 8). The flag is 1 only when the mean is strictly greater than the zero-extended `threshold`, so a mean equal to the threshold gives 0.
- R5: Until eight valid bundles have been accepted since reset or since the last coefficient write, every new result sets the flag to 0.
- R6: A cycle with `smp_valid`=0 leaves the history, the warm-up count and the flag unchanged, whatever `smp_bundle` holds.
- R7: A cycle with `row_we`=1 clears the history, the warm-up count and the flag, the flag reading 0 after that edge. It discards every bundle still in the pipeline and any bundle presented in the same cycle.
- R8: A write with `row_idx` of 24 or more changes no coefficient, though it still restarts the window as in R7.
- R9: A bundle captured at clock edge n sets the flag at edge n+9 (10 edges inclusive) and at no other time. The flag holds between results, and back-to-back bundles give one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_we | input | 1 | Coefficient write strobe; also restarts the window |
| row_idx | input | 5 | Lane index of the coefficient being written |
| row_coef | input | 18 | Signed coefficient value |
| smp_valid | input | 1 | Marks `smp_bundle` as a valid sample bundle |
| smp_bundle | input | 432 | 24 signed 18-bit lanes, lane 0 in the low bits |
| threshold | input | 18 | Unsigned mean-energy threshold in Q-format |
| support_changed | output | 1 | Registered support-change flag |

## Verification
A wrong coefficient, a dropped adder-tree term or a bad rescale shows up as a wrong flag value exactly nine edges after the bundle that exposed it. The bench therefore drives thresholds that sit on and beside the computed mean. A history or warm-up count that is not cleared, or that counts invalid cycles, shows as a flag that rises one or more results too early after a restart or after idle gaps. A stale valid bit left in the pipeline shows as a flag change at a cycle where no result is due. The bench compares the flag on every cycle against a cycle-accurate model, so such a fault is caught on the edge where it first appears.

// File: rtl/scd_pkg.sv
`timescale 1ns/1ps
package scd_pkg;

    // Threshold suggested for typical use: roughly 0.27 in Q14 (4500).
    localparam logic [17:0] SUGGESTED_THRESHOLD = 18'd4500;

    typedef enum logic {
        WIN_FILLING = 1'b0,
        WIN_FULL    = 1'b1
    } win_state_e;

    function automatic int unsigned tree_levels(input int unsigned lanes);
        return (lanes > 1) ? $clog2(lanes) : 1;
    endfunction

    function automatic int unsigned idx_width(input int unsigned lanes);
        return (lanes > 1) ? $clog2(lanes) : 1;
    endfunction

    function automatic int unsigned dot_width(input int unsigned lanes,
                                              input int unsigned smp_w);
        return 2 * smp_w + tree_levels(lanes);
    endfunction

    // capture + product + tree levels + energy + history + flag
    function automatic int unsigned pipe_latency(input int unsigned lanes);
        return 2 + tree_levels(lanes) + 3;
    endfunction

endpackage

// File: rtl/scd_row_store.sv
`timescale 1ns/1ps
module scd_row_store #(
    parameter int unsigned LANES = 24,
    parameter int unsigned SMP_W = 18,
    parameter int unsigned IDX_W = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic signed [SMP_W-1:0] wr_val,
    output logic [LANES*SMP_W-1:0]  row_flat
);

    logic signed [SMP_W-1:0] coef [LANES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LANES; i++) coef[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < LANES; i++) begin
                if (wr_idx == IDX_W'(i)) coef[i] <= wr_val;
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_flat
        assign row_flat[g*SMP_W +: SMP_W] = coef[g];
    end

endmodule

// File: rtl/scd_dot_tree.sv
`timescale 1ns/1ps
module scd_dot_tree #(
    parameter int unsigned LANES = 24,
    parameter int unsigned SMP_W = 18,
    localparam int unsigned LVLS  = scd_pkg::tree_levels(LANES),
    localparam int unsigned DOT_W = scd_pkg::dot_width(LANES, SMP_W)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic                     in_vld,
    input  logic [LANES*SMP_W-1:0]   in_flat,
    input  logic [LANES*SMP_W-1:0]   row_flat,
    output logic                     out_vld,
    output logic signed [DOT_W-1:0]  out_dot
);

    localparam int unsigned PAD = 1 << LVLS;

    logic [LANES*SMP_W-1:0] smp_q;
    logic                   vin_q;
    logic [LVLS:0]          vpipe;
    logic [PAD*SMP_W-1:0]   smp_pad;
    logic [PAD*SMP_W-1:0]   row_pad;

    // input capture stage
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            vin_q <= 1'b0;
            vpipe <= '0;
        end else begin
            vin_q <= in_vld;
            vpipe <= {vpipe[LVLS-1:0], vin_q};
        end
    end

    always_ff @(posedge clk) begin
        if (in_vld) smp_q <= in_flat;
    end

    if (PAD > LANES) begin : g_pad
        assign smp_pad = {{((PAD-LANES)*SMP_W){1'b0}}, smp_q};
        assign row_pad = {{((PAD-LANES)*SMP_W){1'b0}}, row_flat};
    end else begin : g_nopad
        assign smp_pad = smp_q;
        assign row_pad = row_flat;
    end

    for (genvar lvl = 0; lvl <= LVLS; lvl++) begin : g_lvl
        logic signed [DOT_W-1:0] node [PAD >> lvl];
        if (lvl == 0) begin : g_leaf
            always_ff @(posedge clk) begin
                for (int j = 0; j < PAD; j++) begin
                    node[j] <= DOT_W'($signed(smp_pad[j*SMP_W +: SMP_W]))
                             * DOT_W'($signed(row_pad[j*SMP_W +: SMP_W]));
                end
            end
        end else begin : g_add
            always_ff @(posedge clk) begin
                for (int j = 0; j < (PAD >> lvl); j++) begin
                    node[j] <= g_lvl[lvl-1].node[2*j] + g_lvl[lvl-1].node[2*j+1];
                end
            end
        end
    end

    assign out_dot = g_lvl[LVLS].node[0];
    assign out_vld = vpipe[LVLS];

endmodule

// File: rtl/scd_energy_avg.sv
`timescale 1ns/1ps
module scd_energy_avg
    import scd_pkg::*;
#(
    parameter int unsigned DOT_W     = 41,
    parameter int unsigned FRAC_W    = 14,
    parameter int unsigned THR_W     = 18,
    parameter int unsigned HIST_LOG2 = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush,
    input  logic                    dot_vld,
    input  logic signed [DOT_W-1:0] dot,
    input  logic [THR_W-1:0]        thr,
    output logic                    flag
);

    localparam int unsigned DQ_W   = DOT_W - FRAC_W;
    localparam int unsigned SQ_W   = 2 * DQ_W;
    localparam int unsigned EN_W   = SQ_W - FRAC_W;
    localparam int unsigned HIST_N = 1 << HIST_LOG2;
    localparam int unsigned SUM_W  = EN_W + HIST_LOG2;
    localparam int unsigned CNT_W  = HIST_LOG2 + 1;

    logic signed [DQ_W-1:0] dq;
    logic signed [SQ_W-1:0] sq;
    logic [EN_W-1:0]        en_q;
    logic                   e_vld;
    logic                   h_vld;
    logic [EN_W-1:0]        hist [HIST_N];
    logic [CNT_W-1:0]       cnt;
    win_state_e             st;
    logic [SUM_W-1:0]       sum;
    logic [EN_W-1:0]        avg;

    // floor division by 2^FRAC_W of a two's-complement value
    assign dq = dot[DOT_W-1:FRAC_W];
    assign sq = SQ_W'(dq) * SQ_W'(dq);

    always_comb begin
        sum = '0;
        for (int k = 0; k < HIST_N; k++) sum = sum + SUM_W'(hist[k]);
    end

    assign avg = sum[SUM_W-1:HIST_LOG2];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            e_vld <= 1'b0;
            h_vld <= 1'b0;
            en_q  <= '0;
            cnt   <= '0;
            st    <= WIN_FILLING;
            flag  <= 1'b0;
            for (int k = 0; k < HIST_N; k++) hist[k] <= '0;
        end else begin
            e_vld <= dot_vld;
            h_vld <= e_vld;
            if (dot_vld) en_q <= sq[SQ_W-1:FRAC_W];
            if (e_vld) begin
                hist[0] <= en_q;
                for (int k = 1; k < HIST_N; k++) hist[k] <= hist[k-1];
                if (st == WIN_FILLING) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(HIST_N - 1)) st <= WIN_FULL;
                end
            end
            if (h_vld) flag <= (st == WIN_FULL) && (avg > EN_W'(thr));
        end
    end

endmodule

// File: rtl/support_change_det.sv
`timescale 1ns/1ps
module support_change_det #(
    parameter int unsigned LANES     = 24,
    parameter int unsigned SMP_W     = 18,
    parameter int unsigned FRAC_W    = 14,
    parameter int unsigned THR_W     = 18,
    parameter int unsigned HIST_LOG2 = 3
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      row_we,
    input  logic [scd_pkg::idx_width(LANES)-1:0]      row_idx,
    input  logic [SMP_W-1:0]                          row_coef,
    input  logic                                      smp_valid,
    input  logic [LANES*SMP_W-1:0]                    smp_bundle,
    input  logic [THR_W-1:0]                          threshold,
    output logic                                      support_changed
);

    localparam int unsigned IDX_W = scd_pkg::idx_width(LANES);
    localparam int unsigned DOT_W = scd_pkg::dot_width(LANES, SMP_W);

    logic [LANES*SMP_W-1:0]  row_flat;
    logic                    dot_vld;
    logic signed [DOT_W-1:0] dot_val;

    scd_row_store #(
        .LANES (LANES),
        .SMP_W (SMP_W),
        .IDX_W (IDX_W)
    ) row_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (row_we),
        .wr_idx   (row_idx),
        .wr_val   ($signed(row_coef)),
        .row_flat (row_flat)
    );

    scd_dot_tree #(
        .LANES (LANES),
        .SMP_W (SMP_W)
    ) tree_i (
        .clk      (clk),
        .rst      (rst),
        .flush    (row_we),
        .in_vld   (smp_valid),
        .in_flat  (smp_bundle),
        .row_flat (row_flat),
        .out_vld  (dot_vld),
        .out_dot  (dot_val)
    );

    scd_energy_avg #(
        .DOT_W     (DOT_W),
        .FRAC_W    (FRAC_W),
        .THR_W     (THR_W),
        .HIST_LOG2 (HIST_LOG2)
    ) avg_i (
        .clk     (clk),
        .rst     (rst),
        .flush   (row_we),
        .dot_vld (dot_vld),
        .dot     (dot_val),
        .thr     (threshold),
        .flag    (support_changed)
    );

endmodule

// File: rtl/scd_checker.sv
`timescale 1ns/1ps
module scd_checker #(
    parameter int unsigned LANES     = 24,
    parameter int unsigned HIST_LOG2 = 3
) (
    input logic clk,
    input logic rst,
    input logic row_we,
    input logic smp_valid,
    input logic support_changed
);

    localparam int unsigned LAT    = scd_pkg::pipe_latency(LANES);
    localparam int unsigned HIST_N = 1 << HIST_LOG2;

    logic [LAT-1:0]     acc_pipe;
    logic [HIST_LOG2:0] acc_cnt;
    logic               accept;

    assign accept = smp_valid && !row_we;

    always_ff @(posedge clk) begin
        if (rst || row_we) begin
            acc_pipe <= '0;
            acc_cnt  <= '0;
        end else begin
            acc_pipe <= {acc_pipe[LAT-2:0], accept};
            if (accept && acc_cnt != (HIST_LOG2+1)'(HIST_N)) acc_cnt <= acc_cnt + 1'b1;
        end
    end

    // R1
    reset_flag_low_chk: assert property (@(posedge clk)
        rst |=> !support_changed);

    // R7
    restart_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
        row_we |=> !support_changed);

    // R5
    warmup_guard_chk: assert property (@(posedge clk) disable iff (rst)
        support_changed |-> (acc_cnt == (HIST_LOG2+1)'(HIST_N)));

    // R9
    flag_timing_chk: assert property (@(posedge clk) disable iff (rst)
        (support_changed != $past(support_changed)) |-> (acc_pipe[LAT-1] || $past(row_we)));

endmodule

bind support_change_det scd_checker #(
    .LANES     (LANES),
    .HIST_LOG2 (HIST_LOG2)
) chk_i (
    .clk             (clk),
    .rst             (rst),
    .row_we          (row_we),
    .smp_valid       (smp_valid),
    .support_changed (support_changed)
);

// File: tb/support_change_det_tb_top.sv
`timescale 1ns/1ps
module support_change_det_tb_top;

    localparam int NL  = 24;
    localparam int SW  = 18;
    localparam int FR  = 14;
    localparam int LAT = 10;

    typedef struct {
        int due;
        bit f;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            row_we = 1'b0;
    logic [4:0]      row_idx = '0;
    logic [SW-1:0]   row_coef = '0;
    logic            smp_valid = 1'b0;
    logic [NL*SW-1:0] smp_bundle = '0;
    logic [17:0]     threshold = '0;
    logic            support_changed;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit exp_cur = 1'b0;
    string cur_req = "R1";
    exp_t expq[$];

    longint mcoef [NL];
    longint mhist [8];
    int     mcnt = 0;
    logic [31:0] seed = 32'h1ACE_B00C;

    always #2.5 clk = ~clk;

    support_change_det dut_i (
        .clk             (clk),
        .rst             (rst),
        .row_we          (row_we),
        .row_idx         (row_idx),
        .row_coef        (row_coef),
        .smp_valid       (smp_valid),
        .smp_bundle      (smp_bundle),
        .threshold       (threshold),
        .support_changed (support_changed)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // cycle-accurate comparison of the flag
    always @(posedge clk) begin
        cyc++;
        #1;
        if (!rst) begin
            if (expq.size() > 0 && expq[0].due == cyc) begin
                exp_cur = expq[0].f;
                void'(expq.pop_front());
            end
            chk(support_changed === exp_cur, cur_req, longint'(support_changed), longint'(exp_cur));
        end
    end

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic int rnd16();
        seed = nxt(seed);
        seed = nxt(seed);
        return int'(seed[15:0]) - 32768;
    endfunction

    function automatic logic [NL*SW-1:0] pack(input int v [NL]);
        logic [NL*SW-1:0] b;
        for (int i = 0; i < NL; i++) b[i*SW +: SW] = SW'(v[i]);
        return b;
    endfunction

    function automatic longint lane_val(input logic [NL*SW-1:0] b, input int i);
        return longint'($signed(b[i*SW +: SW]));
    endfunction

    task automatic model_flush();
        int w = cyc + 1;
        while (expq.size() > 0 && expq[expq.size()-1].due >= w) void'(expq.pop_back());
        expq.push_back('{w, 1'b0});
        for (int k = 0; k < 8; k++) mhist[k] = 0;
        mcnt = 0;
    endtask

    task automatic model_accept(input logic [NL*SW-1:0] b);
        longint dot = 0;
        longint dq, en, sum;
        bit f;
        for (int i = 0; i < NL; i++) dot += lane_val(b, i) * mcoef[i];
        dq = dot >>> FR;
        en = (dq * dq) >>> FR;
        for (int k = 7; k > 0; k--) mhist[k] = mhist[k-1];
        mhist[0] = en;
        if (mcnt < 8) mcnt++;
        sum = 0;
        for (int k = 0; k < 8; k++) sum += mhist[k];
        f = (mcnt == 8) && ((sum >>> 3) > longint'(threshold));
        expq.push_back('{cyc + 1 + LAT - 1, f});
    endtask

    task automatic idle(input int n, input bit garbage);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            row_we = 1'b0;
            smp_valid = 1'b0;
            if (garbage) begin
                int v [NL];
                for (int i = 0; i < NL; i++) v[i] = rnd16() <<< 1;
                smp_bundle = pack(v);
            end
        end
    endtask

    task automatic push(input logic [NL*SW-1:0] b);
        @(negedge clk);
        row_we = 1'b0;
        smp_valid = 1'b1;
        smp_bundle = b;
        model_accept(b);
    endtask

    task automatic wcoef(input int idx, input int val, input bit with_sample,
                         input logic [NL*SW-1:0] b);
        @(negedge clk);
        row_we = 1'b1;
        row_idx = 5'(idx);
        row_coef = SW'(val);
        smp_valid = with_sample;
        smp_bundle = b;
        if (idx < NL) mcoef[idx] = longint'(val);
        model_flush();
    endtask

    task automatic clear_row();
        for (int i = 0; i < NL; i++) wcoef(i, 0, 1'b0, '0);
    endtask

    task automatic drain();
        idle(LAT + 2, 1'b0);
    endtask

    function automatic logic [NL*SW-1:0] one_lane(input int lane, input int val);
        int v [NL];
        for (int i = 0; i < NL; i++) v[i] = (i == lane) ? val : 0;
        return pack(v);
    endfunction

    // R1: reset state, zero coefficients give zero energy
    task automatic t_reset();
        cur_req = "R1";
        idle(4, 1'b0);
        chk(support_changed == 1'b0, "R1", longint'(support_changed), 0);
        threshold = '0;
        for (int k = 0; k < 10; k++) push(one_lane(k, 30000));
        drain();
        chk(support_changed == 1'b0, "R1", longint'(support_changed), 0);
    endtask

    // R4: mean equal to threshold gives 0, one below gives 1
    task automatic t_equal();
        cur_req = "R4";
        clear_row();
        wcoef(0, 16384, 1'b0, '0);
        threshold = 18'd16384;
        for (int k = 0; k < 8; k++) push(one_lane(0, 16384));
        drain();
        chk(support_changed == 1'b0, "R4", longint'(support_changed), 0);
        threshold = 18'd16383;
        push(one_lane(0, 16384));
        drain();
        chk(support_changed == 1'b1, "R4", longint'(support_changed), 1);
    endtask

    // R3: negative dot product and fraction truncation
    task automatic t_qformat();
        cur_req = "R3";
        wcoef(0, 16384, 1'b0, '0);
        threshold = 18'd36863;
        for (int k = 0; k < 8; k++) push(one_lane(0, -24576));
        drain();
        chk(support_changed == 1'b1, "R3", longint'(support_changed), 1);
        threshold = 18'd36864;
        push(one_lane(0, -24576));
        drain();
        chk(support_changed == 1'b0, "R3", longint'(support_changed), 0);
        threshold = 18'd0;
        wcoef(0, 16384, 1'b0, '0);
        for (int k = 0; k < 9; k++) push(one_lane(0, 100));
        drain();
        chk(support_changed == 1'b0, "R3", longint'(support_changed), 0);
    endtask

    // R5: seven results keep the flag low, the eighth may raise it
    task automatic t_warmup();
        cur_req = "R5";
        wcoef(0, 16384, 1'b0, '0);
        threshold = 18'd0;
        for (int k = 0; k < 7; k++) push(one_lane(0, 20000));
        drain();
        chk(support_changed == 1'b0, "R5", longint'(support_changed), 0);
        push(one_lane(0, 20000));
        drain();
        chk(support_changed == 1'b1, "R5", longint'(support_changed), 1);
    endtask

    // R6: invalid cycles carrying large data are ignored
    task automatic t_ignore();
        cur_req = "R6";
        for (int i = 0; i < NL; i++) wcoef(i, rnd16() >>> 2, 1'b0, '0);
        threshold = 18'd1000;
        for (int k = 0; k < 7; k++) push('0);
        idle(20, 1'b1);
        chk(support_changed == 1'b0, "R6", longint'(support_changed), 0);
        push('0);
        idle(20, 1'b1);
        chk(support_changed == 1'b0, "R6", longint'(support_changed), 0);
    endtask

    // R2: all lanes, sliding window between high and low energy bursts
    task automatic t_lanes();
        cur_req = "R2";
        for (int i = 0; i < NL; i++) wcoef(i, rnd16() >>> 2, 1'b0, '0);
        threshold = 18'd4500;
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 10; k++) begin
                int v [NL];
                for (int i = 0; i < NL; i++) v[i] = rnd16() <<< 1;
                push(pack(v));
            end
            for (int k = 0; k < 12; k++) begin
                int v [NL];
                for (int i = 0; i < NL; i++) v[i] = rnd16() >>> 8;
                push(pack(v));
            end
        end
        drain();
        chk(support_changed == 1'b0, "R2", longint'(support_changed), 0);
        clear_row();
        wcoef(23, 16384, 1'b0, '0);
        threshold = 18'd0;
        for (int k = 0; k < 8; k++) push(one_lane(22, 30000));
        drain();
        chk(support_changed == 1'b0, "R2", longint'(support_changed), 0);
        for (int k = 0; k < 8; k++) push(one_lane(23, 30000));
        drain();
        chk(support_changed == 1'b1, "R2", longint'(support_changed), 1);
    endtask

    // R7: restart mid-stream drops in-flight and same-cycle bundles
    task automatic t_restart();
        cur_req = "R7";
        threshold = 18'd0;
        for (int k = 0; k < 12; k++) push(one_lane(23, 30000));
        wcoef(23, 16384, 1'b1, one_lane(23, 30000));
        idle(1, 1'b0);
        chk(support_changed == 1'b0, "R7", longint'(support_changed), 0);
        for (int k = 0; k < 7; k++) push(one_lane(23, 30000));
        drain();
        chk(support_changed == 1'b0, "R7", longint'(support_changed), 0);
        push(one_lane(23, 30000));
        drain();
        chk(support_changed == 1'b1, "R7", longint'(support_changed), 1);
    endtask

    // R8: indices past the last lane write nothing
    task automatic t_bad_idx();
        int v [NL];
        cur_req = "R8";
        clear_row();
        for (int i = NL; i < 32; i++) wcoef(i, 16384, 1'b0, '0);
        threshold = 18'd0;
        for (int i = 0; i < NL; i++) v[i] = 16384;
        for (int k = 0; k < 10; k++) push(pack(v));
        drain();
        chk(support_changed == 1'b0, "R8", longint'(support_changed), 0);
    endtask

    // R9: single result lands exactly LAT edges after capture
    task automatic t_latency();
        int c0;
        cur_req = "R9";
        wcoef(0, 16384, 1'b0, '0);
        threshold = 18'd100;
        for (int k = 0; k < 8; k++) push('0);
        drain();
        push(one_lane(0, 16384));
        c0 = cyc + 1;
        @(negedge clk);
        smp_valid = 1'b0;
        while (cyc < c0 + LAT - 2) @(negedge clk);
        chk(support_changed == 1'b0, "R9", longint'(support_changed), 0);
        @(negedge clk);
        chk(support_changed == 1'b1, "R9", longint'(support_changed), 1);
        drain();
        for (int k = 0; k < 8; k++) push('0);
        drain();
        chk(support_changed == 1'b0, "R9", longint'(support_changed), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NL; i++) mcoef[i] = 0;
        for (int k = 0; k < 8; k++) mhist[k] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_equal();
        t_qformat();
        t_warmup();
        t_ignore();
        t_lanes();
        t_restart();
        t_bad_idx();
        t_latency();
        idle(2, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule